// File: doc/BRIEF.md
# Bounded-Window Out-of-Order Read Response Engine

This engine sits on the read side of a memory-mapped slave. Read requests arrive on a valid/ready channel, each carrying a transaction ID, a start address, a burst length and a latency value. A fixed number of slots, the reordering window, hold the transactions that are in service. Each slot counts its latency down to zero. Once a slot's count is zero and no older slot holds the same ID, that slot may return its burst. Transactions with different IDs therefore finish in whatever order their latencies allow, while transactions that share an ID leave in the order they were accepted.

When every slot is busy, accepted requests wait in an arrival-order queue. Each time a slot frees, the queue's oldest entry moves into it. The address channel stalls only when that queue is full. When several slots are ready at once, a round-robin choice picks the one that drives the response channel. The chosen burst then owns the channel until its last beat is taken. Response data is derived from the beat address, so a checker can tie every beat back to its request.

Top module: `ooo_read_engine`

## Requirements
- R1: No more than DEPTH (default 4) transactions are in service at once. A request that finds every slot taken is not served until a slot is released.
- R2: Transactions with different IDs respond in the order their latencies expire, not in the order they were issued. IDs 3, 2, 1, 0 with latencies 40, 30, 20, 10 return as 0, 1, 2, 3.
- R3: A transaction never starts its response while an older transaction with the same ID is still in service, even when its own latency has expired.
- R4: With DEPTH set to 1, responses leave in exactly the order the requests were accepted, whatever their latencies.
- R5: Waiting requests enter the window strictly in arrival order. A slot that frees is given to the oldest waiting request.
- R6: While rsp_valid is high and rsp_ready is low, rsp_id, rsp_data and rsp_last hold their values and rsp_valid stays high.
- R7: A request with length field N returns exactly N+1 beats on consecutive accepted transfers. rsp_last is high on the final beat only, and no other transaction's beat comes between them.
- R8: After reset, rsp_valid is 0 and req_ready is 1. req_ready falls only when the pending queue (QDEPTH entries, default 4) is full. With every slot busy, DEPTH+QDEPTH requests are accepted back to back before req_ready drops.
- R9: A slot is released in the cycle after its final beat is accepted, at edge E. A waiting request with latency L that takes that slot, and is then the only one eligible, presents its first beat from edge E+L+2 onward.
- R10: Beat k of a request at address A carries data {~B, B}, where B = (A + k) modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (pending queue not full) |
| req_id | input | ID_W | Transaction ID |
| req_addr | input | ADDR_W | Start address of the burst |
| req_len | input | LEN_W | Beats minus one |
| req_lat | input | LAT_W | Cycles the slot waits before it may respond |
| rsp_valid | output | 1 | Response beat offered |
| rsp_ready | input | 1 | Response beat taken |
| rsp_id | output | ID_W | ID of the transaction being returned |
| rsp_data | output | 2*ADDR_W | Beat data, derived from the beat address |
| rsp_last | output | 1 | Final beat of the burst |

## Verification
The directed cases target the points where an engine of this kind usually breaks. One case gives a same-ID request a shorter latency than its older sibling: a design without the ID guard returns the younger one first. A ten-request run with three long-latency requests in the window checks that the other slot frees and refills in arrival order, with an exact cycle gap between completions. A design with an extra slot, a late release or a reordered queue shifts that gap or the order. Two bursts under toggling backpressure expose interleaving, unstable held beats and a misplaced last flag. A depth-one instance confirms strict arrival order. A back-to-back fill confirms that the address channel stalls at exactly DEPTH+QDEPTH outstanding requests.

// File: rtl/ooo_rd_pkg.sv
package ooo_rd_pkg;

    typedef enum logic {
        RSP_IDLE = 1'b0,
        RSP_SEND = 1'b1
    } rsp_st_e;

    // index width that never collapses to zero
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ooo_req_fifo.sv
module ooo_req_fifo
    import ooo_rd_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int unsigned PW = idx_w(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PW-1:0]               rd;
        logic [PW-1:0]               wr;
        logic [CW-1:0]               cnt;
    } fifo_t;

    fifo_t fifo_q, fifo_d;

    always_comb begin
        fifo_d = fifo_q;
        if (push) begin
            fifo_d.mem[fifo_q.wr] = din;
            fifo_d.wr = (fifo_q.wr == PW'(DEPTH - 1)) ? '0 : fifo_q.wr + 1'b1;
        end
        if (pop) begin
            fifo_d.rd = (fifo_q.rd == PW'(DEPTH - 1)) ? '0 : fifo_q.rd + 1'b1;
        end
        fifo_d.cnt = fifo_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end

    assign dout  = fifo_q.mem[fifo_q.rd];
    assign empty = (fifo_q.cnt == '0);
    assign full  = (fifo_q.cnt == CW'(DEPTH));

endmodule

// File: rtl/ooo_rr_pick.sv
module ooo_rr_pick #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic [IW-1:0] gnt,
    output logic          any
);
    int c;

    // scan starts one past the last winner and wraps
    always_comb begin
        gnt = '0;
        any = 1'b0;
        c   = 0;
        for (int k = 1; k <= int'(N); k++) begin
            c = (int'(last) + k) % int'(N);
            if (!any && req[c]) begin
                any = 1'b1;
                gnt = IW'(c);
            end
        end
    end

endmodule

// File: rtl/ooo_order_guard.sv
module ooo_order_guard #(
    parameter int unsigned N    = 4,
    parameter int unsigned ID_W = 4
) (
    input  logic [N-1:0]           vld,
    input  logic [N-1:0][ID_W-1:0] id,
    input  logic [N-1:0][N-1:0]    older,
    output logic [N-1:0]           blocked
);
    // slot i is held back by any live, older slot j with the same ID
    for (genvar i = 0; i < N; i++) begin : g_row
        always_comb begin
            blocked[i] = 1'b0;
            for (int j = 0; j < int'(N); j++) begin
                if (vld[j] && older[i][j] && (id[j] == id[i])) blocked[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ooo_read_engine.sv
module ooo_read_engine
    import ooo_rd_pkg::*;
#(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned QDEPTH = 4,
    parameter int unsigned ID_W   = 4,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned LEN_W  = 4,
    parameter int unsigned LAT_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ID_W-1:0]     req_id,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [LEN_W-1:0]    req_len,
    input  logic [LAT_W-1:0]    req_lat,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic [ID_W-1:0]     rsp_id,
    output logic [2*ADDR_W-1:0] rsp_data,
    output logic                rsp_last
);
    localparam int unsigned SLOT_W = idx_w(DEPTH);
    localparam int unsigned DATA_W = 2 * ADDR_W;
    localparam int unsigned ENT_W  = ID_W + ADDR_W + LEN_W + LAT_W;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [LAT_W-1:0]  lat;
    } ent_t;

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][ID_W-1:0]   id;
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][LEN_W-1:0]  len;
        logic [DEPTH-1:0][LAT_W-1:0]  cnt;
        logic [DEPTH-1:0][DEPTH-1:0]  older;
        rsp_st_e                      st;
        logic [SLOT_W-1:0]            cur;
        logic [LEN_W-1:0]             beat;
        logic [SLOT_W-1:0]            rr;
    } eng_t;

    eng_t eng_q, eng_d;

    // pending queue
    ent_t             push_ent, head;
    logic [ENT_W-1:0] head_bits;
    logic             q_empty, q_full;
    logic             admit;

    assign push_ent = '{id: req_id, addr: req_addr, len: req_len, lat: req_lat};
    assign req_ready = !q_full;

    ooo_req_fifo #(
        .WIDTH (ENT_W),
        .DEPTH (QDEPTH)
    ) pend_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (req_valid && !q_full),
        .din   (push_ent),
        .pop   (admit),
        .dout  (head_bits),
        .empty (q_empty),
        .full  (q_full)
    );

    assign head = ent_t'(head_bits);

    // free slot search, lowest index wins
    logic              free_any;
    logic [SLOT_W-1:0] free_idx;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = int'(DEPTH) - 1; i >= 0; i--) begin
            if (!eng_q.vld[i]) begin
                free_any = 1'b1;
                free_idx = SLOT_W'(i);
            end
        end
    end

    assign admit = free_any && !q_empty;

    // same-ID ordering
    logic [DEPTH-1:0] blocked;

    ooo_order_guard #(
        .N    (DEPTH),
        .ID_W (ID_W)
    ) guard_i (
        .vld     (eng_q.vld),
        .id      (eng_q.id),
        .older   (eng_q.older),
        .blocked (blocked)
    );

    // eligible slots, offered to the arbiter only while the channel is idle
    logic [DEPTH-1:0]  elig;
    logic [SLOT_W-1:0] gnt;
    logic              gnt_any;

    always_comb begin
        for (int i = 0; i < int'(DEPTH); i++) begin
            elig[i] = eng_q.vld[i] && (eng_q.cnt[i] == '0) && !blocked[i]
                      && (eng_q.st == RSP_IDLE);
        end
    end

    ooo_rr_pick #(
        .N  (DEPTH),
        .IW (SLOT_W)
    ) arb_i (
        .req  (elig),
        .last (eng_q.rr),
        .gnt  (gnt),
        .any  (gnt_any)
    );

    // response view of the owning slot
    logic              beat_take;
    logic              final_beat;
    logic [ADDR_W-1:0] beat_addr;

    assign final_beat = (eng_q.beat == eng_q.len[eng_q.cur]);
    assign beat_take  = (eng_q.st == RSP_SEND) && rsp_ready;
    assign beat_addr  = eng_q.addr[eng_q.cur] + ADDR_W'(eng_q.beat);

    always_comb begin
        eng_d = eng_q;

        // latency countdown
        for (int i = 0; i < int'(DEPTH); i++) begin
            if (eng_q.vld[i] && (eng_q.cnt[i] != '0)) eng_d.cnt[i] = eng_q.cnt[i] - 1'b1;
        end

        // response channel ownership
        unique case (eng_q.st)
            RSP_IDLE: begin
                if (gnt_any) begin
                    eng_d.st   = RSP_SEND;
                    eng_d.cur  = gnt;
                    eng_d.beat = '0;
                end
            end
            RSP_SEND: begin
                if (beat_take) begin
                    if (final_beat) begin
                        eng_d.vld[eng_q.cur] = 1'b0;
                        eng_d.st             = RSP_IDLE;
                        eng_d.rr             = eng_q.cur;
                    end else begin
                        eng_d.beat = eng_q.beat + 1'b1;
                    end
                end
            end
            default: eng_d.st = RSP_IDLE;
        endcase

        // admission of the oldest waiting request
        if (admit) begin
            eng_d.vld[free_idx]  = 1'b1;
            eng_d.id[free_idx]   = head.id;
            eng_d.addr[free_idx] = head.addr;
            eng_d.len[free_idx]  = head.len;
            eng_d.cnt[free_idx]  = head.lat;
            for (int i = 0; i < int'(DEPTH); i++) begin
                eng_d.older[i][free_idx] = 1'b0;
            end
            eng_d.older[free_idx] = eng_q.vld;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign rsp_valid = (eng_q.st == RSP_SEND);
    assign rsp_id    = eng_q.id[eng_q.cur];
    assign rsp_last  = final_beat;
    assign rsp_data  = DATA_W'({~beat_addr, beat_addr});

    // observation points for the bound checker
    logic [DEPTH-1:0]  slot_vld;
    logic [SLOT_W-1:0] cur_slot;
    assign slot_vld = eng_q.vld;
    assign cur_slot = eng_q.cur;

endmodule

// File: rtl/ooo_read_engine_chk.sv
module ooo_read_engine_chk #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned QDEPTH = 4,
    parameter int unsigned ID_W   = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SLOT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ID_W-1:0]   rsp_id,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_last,
    input logic [DEPTH-1:0]  slot_vld,
    input logic [SLOT_W-1:0] cur_slot
);
    localparam int unsigned OW = $clog2(DEPTH + QDEPTH + 1) + 1;

    logic [OW-1:0] outstanding;

    always_ff @(posedge clk) begin
        if (!rst_n) outstanding <= '0;
        else outstanding <= outstanding + OW'(req_valid && req_ready)
                                        - OW'(rsp_valid && rsp_ready && rsp_last);
    end

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_id) && $stable(rsp_data) && $stable(rsp_last));

    a_r7_no_interleave: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready && !rsp_last |=> rsp_valid && (rsp_id == $past(rsp_id)));

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready && rsp_last |=> !slot_vld[$past(cur_slot)]);

    a_r8_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= OW'(DEPTH + QDEPTH));

    a_r8_ready_full: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> outstanding >= OW'(QDEPTH));

    a_r1_window: assert property (@(posedge clk) disable iff (!rst_n)
        OW'($countones(slot_vld)) <= outstanding);

endmodule

bind ooo_read_engine ooo_read_engine_chk #(
    .DEPTH  (DEPTH),
    .QDEPTH (QDEPTH),
    .ID_W   (ID_W),
    .DATA_W (DATA_W),
    .SLOT_W (SLOT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_id    (rsp_id),
    .rsp_data  (rsp_data),
    .rsp_last  (rsp_last),
    .slot_vld  (slot_vld),
    .cur_slot  (cur_slot)
);

// File: tb/ooo_read_engine_tb_top.sv
module ooo_read_engine_tb_top;
    localparam int ID_W = 4, ADDR_W = 16, LEN_W = 4, LAT_W = 8, DW = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;
    logic rst_n = 1'b0;
    int   cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // main instance, default window
    logic              req_valid = 0, req_ready, rsp_valid, rsp_ready = 1, rsp_last;
    logic [ID_W-1:0]   req_id = 0, rsp_id;
    logic [ADDR_W-1:0] req_addr = 0;
    logic [LEN_W-1:0]  req_len = 0;
    logic [LAT_W-1:0]  req_lat = 0;
    logic [DW-1:0]     rsp_data;

    ooo_read_engine dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_id(req_id), .req_addr(req_addr), .req_len(req_len), .req_lat(req_lat),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id),
        .rsp_data(rsp_data), .rsp_last(rsp_last));

    // second instance with a window of one
    logic              s_valid = 0, s_ready, s_rvalid, s_rlast;
    logic [ID_W-1:0]   s_id = 0, s_rid;
    logic [ADDR_W-1:0] s_addr = 0;
    logic [LEN_W-1:0]  s_len = 0;
    logic [LAT_W-1:0]  s_lat = 0;
    logic [DW-1:0]     s_rdata;

    ooo_read_engine #(.DEPTH(1)) dut_d1_i (
        .clk(clk), .rst_n(rst_n), .req_valid(s_valid), .req_ready(s_ready),
        .req_id(s_id), .req_addr(s_addr), .req_len(s_len), .req_lat(s_lat),
        .rsp_valid(s_rvalid), .rsp_ready(1'b1), .rsp_id(s_rid),
        .rsp_data(s_rdata), .rsp_last(s_rlast));

    int checks = 0, errors = 0, mon_checks = 0, mon_errs = 0;
    bit done = 0;

    // response recorders, sampled at the falling edge
    logic [ID_W-1:0] rec_id   [512];
    logic [DW-1:0]   rec_data [512];
    logic            rec_last [512];
    int              rec_cyc  [512];
    int              rec_n = 0;
    logic [ID_W-1:0] s_rec_id   [64];
    logic [DW-1:0]   s_rec_data [64];
    int              s_rec_n = 0;

    logic            stall_prev = 0;
    logic [ID_W-1:0] id_prev;
    logic [DW-1:0]   data_prev;
    logic            last_prev;

    always @(negedge clk) begin
        if (stall_prev) begin
            mon_checks++;
            if (!(rsp_valid && rsp_id == id_prev && rsp_data == data_prev && rsp_last == last_prev)) begin
                mon_errs++;
                $display("FAIL R6 held beat changed: actual id %0h data %0h, expected id %0h data %0h",
                         rsp_id, rsp_data, id_prev, data_prev);
            end
        end
        stall_prev = rst_n && rsp_valid && !rsp_ready;
        id_prev = rsp_id; data_prev = rsp_data; last_prev = rsp_last;
        if (rst_n && rsp_valid && rsp_ready) begin
            rec_id[rec_n] = rsp_id; rec_data[rec_n] = rsp_data;
            rec_last[rec_n] = rsp_last; rec_cyc[rec_n] = cyc;
            rec_n++;
        end
        if (rst_n && s_rvalid) begin
            s_rec_id[s_rec_n] = s_rid; s_rec_data[s_rec_n] = s_rdata;
            s_rec_n++;
        end
    end

    function automatic logic [DW-1:0] dexp(input logic [ADDR_W-1:0] a, input int k);
        logic [ADDR_W-1:0] b;
        b = a + ADDR_W'(k);
        return {~b, b};
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic send(input int id, input int addr, input int len, input int lat);
        req_valid = 1; req_id = ID_W'(id); req_addr = ADDR_W'(addr);
        req_len = LEN_W'(len); req_lat = LAT_W'(lat);
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic s_send(input int id, input int addr, input int lat);
        s_valid = 1; s_id = ID_W'(id); s_addr = ADDR_W'(addr);
        s_len = '0; s_lat = LAT_W'(lat);
        do @(negedge clk); while (!s_ready);
        @(posedge clk); #1;
        s_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_recs(input int target, input int limit);
        int t = 0;
        while (rec_n < target && t < limit) begin @(posedge clk); t++; end
        #1;
        check(rec_n >= target, "R7", "response count", rec_n, target);
    endtask

    task automatic t_reset();
        check(rsp_valid == 1'b0, "R8", "rsp_valid after reset", rsp_valid, 0);
        check(req_ready == 1'b1, "R8", "req_ready after reset", req_ready, 1);
    endtask

    // R2: distinct IDs finish by latency
    task automatic t_reorder();
        int base = rec_n;
        send(3, 'h130, 0, 40); send(2, 'h120, 0, 30);
        send(1, 'h110, 0, 20); send(0, 'h100, 0, 10);
        wait_recs(base + 4, 300);
        for (int k = 0; k < 4; k++) begin
            check(rec_id[base+k] == ID_W'(k), "R2", "reorder id", rec_id[base+k], k);
            check(rec_data[base+k] == dexp(ADDR_W'('h100 + 16*k), 0), "R10", "reorder data",
                  rec_data[base+k], dexp(ADDR_W'('h100 + 16*k), 0));
        end
    endtask

    // R3: a short-latency younger same-ID request waits for its elder
    task automatic t_same_id();
        int base = rec_n;
        logic [ADDR_W-1:0] ea [3] = '{'h400, 'h200, 'h300};
        send(5, 'h200, 0, 40); send(5, 'h300, 0, 0); send(6, 'h400, 0, 5);
        wait_recs(base + 3, 300);
        for (int k = 0; k < 3; k++)
            check(rec_data[base+k] == dexp(ea[k], 0), "R3", "same-id order",
                  rec_data[base+k], dexp(ea[k], 0));
    endtask

    // R7, R10, R6: two bursts under backpressure
    task automatic t_burst();
        int base = rec_n;
        rsp_ready = 0;
        send(1, 'h0500, 3, 6); send(2, 'h0FFE, 3, 6);
        idle(20);
        while (rec_n < base + 8 && cyc < 140000) begin @(posedge clk); #1; rsp_ready = ~rsp_ready; end
        rsp_ready = 1;
        wait_recs(base + 8, 50);
        for (int k = 0; k < 8; k++) begin
            int eid = (k < 4) ? 1 : 2;
            logic [ADDR_W-1:0] ea = (k < 4) ? ADDR_W'('h0500) : ADDR_W'('h0FFE);
            check(rec_id[base+k] == ID_W'(eid), "R7", "burst beat id", rec_id[base+k], eid);
            check(rec_data[base+k] == dexp(ea, k % 4), "R10", "burst beat data",
                  rec_data[base+k], dexp(ea, k % 4));
            check(rec_last[base+k] == ((k % 4) == 3), "R7", "last flag", rec_last[base+k], (k % 4) == 3);
        end
    endtask

    // R1, R5, R9: ten requests, three long ones pin the window
    task automatic t_queue();
        int base = rec_n;
        int eo [10] = '{6, 5, 4, 3, 2, 1, 0, 9, 8, 7};
        for (int id = 9; id >= 0; id--) send(id, 'h1000 + 16*id, 0, (id >= 7) ? 200 : 4);
        wait_recs(base + 10, 800);
        for (int k = 0; k < 10; k++)
            check(rec_id[base+k] == ID_W'(eo[k]), "R5", "admission order", rec_id[base+k], eo[k]);
        check(rec_cyc[base+1] - rec_cyc[base] == 7, "R1", "gap before refill response",
              rec_cyc[base+1] - rec_cyc[base], 7);
        for (int k = 2; k < 7; k++)
            check(rec_cyc[base+k] - rec_cyc[base+k-1] == 7, "R9", "release-to-response gap",
                  rec_cyc[base+k] - rec_cyc[base+k-1], 7);
    endtask

    // R8: stall exactly at window plus queue
    task automatic t_full();
        int base = rec_n;
        int t0 = cyc;
        for (int i = 0; i < 8; i++) send(i, 'h2000 + 16*i, 0, 250);
        check(cyc - t0 == 8, "R8", "edges for eight back-to-back requests", cyc - t0, 8);
        idle(2);
        check(req_ready == 1'b0, "R8", "req_ready with queue full", req_ready, 0);
        wait_recs(base + 8, 600);
        idle(2);
        check(req_ready == 1'b1, "R8", "req_ready after drain", req_ready, 1);
    endtask

    // R4: depth one keeps arrival order
    task automatic t_depth1();
        int base = s_rec_n;
        int t = 0;
        s_send(3, 'h30, 30); s_send(2, 'h20, 20); s_send(1, 'h10, 10); s_send(0, 'h00, 0);
        while (s_rec_n < base + 4 && t < 400) begin @(posedge clk); t++; end
        #1;
        check(s_rec_n == base + 4, "R4", "depth-one count", s_rec_n - base, 4);
        for (int k = 0; k < 4; k++) begin
            check(s_rec_id[base+k] == ID_W'(3 - k), "R4", "depth-one id", s_rec_id[base+k], 3 - k);
            check(s_rec_data[base+k] == dexp(ADDR_W'(16*(3-k)), 0), "R4", "depth-one data",
                  s_rec_data[base+k], dexp(ADDR_W'(16*(3-k)), 0));
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        idle(1);
        t_reset();
        t_reorder();  idle(5);
        t_same_id();  idle(5);
        t_burst();    idle(5);
        t_queue();    idle(5);
        t_full();     idle(5);
        t_depth1();   idle(5);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errs);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        if (!done) begin
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errs + 1);
            $finish;
        end
    end

endmodule